// File: doc/BRIEF.md
# Keyboard Scancode Receiver

This block takes bytes that a keyboard sends to the host over a shared open-drain two-wire link in which the keyboard owns the clock. The host side only listens. The block synchronises both link lines into the system clock and reads the data line on each rising edge of the link clock. It builds a byte from eight data bits, least significant bit first, and checks one odd-parity bit. A correct byte is presented with a single-cycle valid strobe. A bad parity bit, or a start bit that never arrives, drops the frame, raises an error strobe and asks a companion transmitter to send the resend command.

A separate inhibit input drives the data line low through an open-drain enable, which stops the keyboard from sending. While the companion transmitter reports busy, reception is held idle. A stalled frame is abandoned after a programmable silence, so a partial frame never leaks into the next one.

Top module: `kbd_rx`

## Requirements
- R1: After reset, `byte_vld_o`, `err_parity_o`, `err_frame_o` and `resend_req_o` are low, and `byte_o` is 0x00.
- R2: Data bits are taken on the rising edges of the link clock that follow the start rising edge. Bit 0 comes first. After the ninth such edge (the parity edge), a good frame gives exactly one cycle of `byte_vld_o`. `byte_o` then holds the byte and does not change until the next valid strobe.
- R3: The eight data bits plus the parity bit must hold an odd number of ones. Otherwise the frame gives one cycle of `err_parity_o` and no valid strobe.
- R4: The first rising edge of the link clock in idle starts a frame. If the data line is not seen low within `START_WIN` cycles after that, the block gives one cycle of `err_frame_o` and returns to idle.
- R5: Every parity or framing error gives exactly one cycle of `resend_req_o`. `resend_cmd_o` always carries 0xFE.
- R6: If no rising edge of the link clock arrives for `IDLE_TMO` cycles in the middle of a frame, the block returns to idle with no strobe. A following full frame is received correctly.
- R7: While `tx_busy_i` is high, link traffic produces no strobe. Reception after busy drops is unaffected.
- R8: `dat_oe_o` is high exactly while `inhibit_i` is high. A high `dat_oe_o` means the data line is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kb_clk_i | input | 1 | Link clock line as seen at the pin |
| kb_dat_i | input | 1 | Link data line as seen at the pin |
| inhibit_i | input | 1 | Request to block the keyboard from sending |
| tx_busy_i | input | 1 | Companion transmitter is using the link |
| dat_oe_o | output | 1 | Open-drain enable that pulls the data line low |
| byte_o | output | 8 | Last byte received correctly |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| err_parity_o | output | 1 | One-cycle strobe for a parity error |
| err_frame_o | output | 1 | One-cycle strobe for a missing start bit |
| resend_req_o | output | 1 | One-cycle request to the transmitter to send the resend command |
| resend_cmd_o | output | 8 | Command byte to transmit on a resend request |

## Verification
The bench builds the block with `START_WIN` = 8 and `IDLE_TMO` = 40 instead of the microsecond-scale defaults. With these values, a late start bit and an abandoned frame each fall within a few dozen system cycles. A link half-period of 4 cycles keeps each frame well under the timeout, so an abort only happens when the bench stalls on purpose.

// File: rtl/kbd_rx.sv
module kbd_rx #(
  parameter int START_WIN = 500,
  parameter int IDLE_TMO  = 100000,
  parameter logic [7:0] RESEND_CMD = 8'hFE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kb_clk_i,
  input  logic       kb_dat_i,
  input  logic       inhibit_i,
  input  logic       tx_busy_i,
  output logic       dat_oe_o,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       err_parity_o,
  output logic       err_frame_o,
  output logic       resend_req_o,
  output logic [7:0] resend_cmd_o
);
  localparam int CW = $clog2(IDLE_TMO + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} st_t;

  st_t        st;
  logic [2:0] cs;
  logic [1:0] ds;
  logic [CW-1:0] cnt;
  logic [3:0] nbit;
  logic [7:0] sh;
  logic       par;

  wire rise = cs[1] & ~cs[2];
  wire din  = ds[1];

  assign dat_oe_o     = inhibit_i;
  assign resend_cmd_o = RESEND_CMD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs <= 3'b111;
      ds <= 2'b11;
    end else begin
      cs <= {cs[1:0], kb_clk_i};
      ds <= {ds[0], kb_dat_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; nbit <= '0; sh <= '0; par <= 1'b0;
      byte_o <= '0; byte_vld_o <= 1'b0; err_parity_o <= 1'b0;
      err_frame_o <= 1'b0; resend_req_o <= 1'b0;
    end else begin
      byte_vld_o   <= 1'b0;
      err_parity_o <= 1'b0;
      err_frame_o  <= 1'b0;
      resend_req_o <= 1'b0;
      if (tx_busy_i) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (rise) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: begin
            if (!din) begin
              st <= S_BITS; cnt <= '0; nbit <= '0; sh <= '0; par <= 1'b0;
            end else if (cnt == CW'(START_WIN - 1)) begin
              err_frame_o  <= 1'b1;
              resend_req_o <= 1'b1;
              st <= S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            if (rise) begin
              cnt <= '0;
              if (nbit == 4'd8) begin
                st <= S_IDLE;
                if (par ^ din) begin
                  byte_o     <= sh;
                  byte_vld_o <= 1'b1;
                end else begin
                  err_parity_o <= 1'b1;
                  resend_req_o <= 1'b1;
                end
              end else begin
                sh   <= {din, sh[7:1]};
                par  <= par ^ din;
                nbit <= nbit + 1'b1;
              end
            end else if (cnt == CW'(IDLE_TMO - 1)) begin
              st <= S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  a_r2_vld_after_parity_edge: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> ($past(nbit) == 4'd8 && $past(st) == S_BITS));
  a_r2_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld_o |-> $stable(byte_o));
  a_r4_frame_err_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame_o |-> $past(st) == S_START);
  a_r5_no_resend_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld_o && resend_req_o));
  a_r7_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req_o |-> !$past(tx_busy_i));
endmodule

// File: tb/tb_kbd_rx.sv
module tb_kbd_rx;
  localparam int CLK_PERIOD = 10;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic kc = 1'b1, kd = 1'b1, inh = 1'b0, busy = 1'b0;
  logic dat_oe; logic [7:0] byte_q, rcmd;
  logic vld, perr, ferr, rsnd;

  kbd_rx #(.START_WIN(8), .IDLE_TMO(40)) dut (
    .clk(clk), .rst_n(rst_n), .kb_clk_i(kc), .kb_dat_i(kd),
    .inhibit_i(inh), .tx_busy_i(busy), .dat_oe_o(dat_oe),
    .byte_o(byte_q), .byte_vld_o(vld), .err_parity_o(perr),
    .err_frame_o(ferr), .resend_req_o(rsnd), .resend_cmd_o(rcmd));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int nv = 0, np = 0, nf = 0, nr = 0;
  logic [7:0] got = '0;

  always @(negedge clk) if (rst_n) begin
    if (vld) begin nv++; got = byte_q; end
    if (perr) np++;
    if (ferr) nf++;
    if (rsnd) nr++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    nv = 0; np = 0; nf = 0; nr = 0;
  endtask

  function automatic logic par_bit(input logic [7:0] b, input bit good);
    return good ? ~^b : ^b;
  endfunction

  task automatic frame(input logic [7:0] b, input bit good, input int sdly);
    kc = 0; w(H); kc = 1; w(sdly); kd = 0; w(H);
    for (int i = 0; i < 9; i++) begin
      kc = 0; kd = (i < 8) ? b[i] : par_bit(b, good); w(H);
      kc = 1; w(H);
    end
    kd = 0; w(H); kd = 1; w(10);
  endtask

  task automatic expect_frame(input logic [7:0] b, input bit good, input string req);
    if (good) begin
      check(nv == 1, req, nv, 1);
      check(got == b, req, got, b);
      check(np == 0 && nr == 0, req, nr, 0);
    end else begin
      check(nv == 0, req, nv, 0);
      check(np == 1, req, np, 1);
      check(nr == 1 && rcmd == 8'hFE, req, rcmd, 8'hFE);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] last;
    void'($urandom(32'd1234));
    w(3); rst_n = 1; w(2);
    check(!vld && !perr && !ferr && !rsnd, "R1", {vld, perr, ferr, rsnd}, 0);
    check(byte_q == 8'h00, "R1", byte_q, 0);
    check(rcmd == 8'hFE, "R5", rcmd, 8'hFE);

    inh = 1; w(1); check(dat_oe == 1, "R8", dat_oe, 1);
    inh = 0; w(1); check(dat_oe == 0, "R8", dat_oe, 0);

    clr(); frame(8'hA5, 1, 1); expect_frame(8'hA5, 1, "R2");
    clr(); frame(8'h01, 1, 1); expect_frame(8'h01, 1, "R2");
    clr(); frame(8'h80, 1, 1); expect_frame(8'h80, 1, "R2");
    last = 8'h80;
    clr(); frame(8'h3C, 0, 1); expect_frame(8'h3C, 0, "R3");
    check(byte_q == last, "R2", byte_q, last);

    clr(); kc = 0; w(H); kc = 1; w(30); kd = 0; w(H); kd = 1; w(20);
    check(nf == 1, "R4", nf, 1);
    check(nr == 1, "R5", nr, 1);
    check(nv == 0, "R4", nv, 0);
    clr(); frame(8'h5A, 1, 5); expect_frame(8'h5A, 1, "R4");

    clr(); kc = 0; w(H); kc = 1; w(1); kd = 0; w(H);
    for (int i = 0; i < 3; i++) begin kc = 0; kd = 1; w(H); kc = 1; w(H); end
    w(60); kd = 1; w(5);
    check(nv == 0 && np == 0 && nf == 0, "R6", nv + np + nf, 0);
    frame(8'hC3, 1, 1); expect_frame(8'hC3, 1, "R6");

    clr(); busy = 1; frame(8'h77, 1, 1); frame(8'h76, 0, 1); busy = 0; w(5);
    check(nv == 0 && np == 0 && nr == 0, "R7", nv + np + nr, 0);
    frame(8'h11, 1, 1); expect_frame(8'h11, 1, "R7");

    for (int k = 0; k < 24; k++) begin
      logic [7:0] b; bit g;
      b = 8'($urandom_range(255));
      g = ($urandom_range(3) != 0);
      clr(); frame(b, g, int'($urandom_range(3)));
      expect_frame(b, g, g ? "R2" : "R3");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule